// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is the device-side register file of a command mailbox. A host processor reaches it over a plain 32-bit memory-mapped read/write bus. The host stages up to sixteen payload bytes and two pointer words, then writes a command word. That write hands the whole transaction to an embedded controller in a single-cycle start pulse and marks the mailbox busy.

The controller answers with a done pulse. The pulse carries an 8-bit result code and up to four response words. The block loads the response words into a read buffer and drops busy. It latches the result code, and raises a level interrupt if the command asked for one. The host polls busy or takes the interrupt. It then reads the status and the response words, and clears the interrupt by writing a one to the flag.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the command, status, pointer and buffer registers read 0, `host_irq` is 0 and `ctl_start` is 0.
- R2: The source pointer (offset 0x08), the destination pointer (0x0C) and the write buffer words (0x80 + 4*i) read back the last value written. Read data appears on `bus_rdata` one cycle after `bus_rd`, and unmapped offsets read 0.
- R3: A command write (offset 0x00) while idle sets busy (status bit 0) and pulses `ctl_start` for exactly one cycle. The pulse carries the code from bits 7:0, the subcommand from bits 15:12, the size from bits 23:16 and both pointers.
- R4: `ctl_payload` holds payload byte k (the byte in lane k%4 of write-buffer word k/4) when k < size, and 0 otherwise. A size above 16 passes all bytes.
- R5: A command write while busy is ignored: there is no start pulse and the command register keeps its value. Sticky overrun status bit 24 is set and stays set until reset.
- R6: A done pulse while busy clears busy and loads the four response words, which read back at 0x90 + 4*i.
- R7: After done, status bits 23:16 hold the result code, and status bit 1 is 1 exactly when that code is non-zero.
- R8: If command bit 8 was set, done sets status bit 2 and `host_irq`. Both stay set until a status write with bit 2 = 1. A status write with bit 2 = 0 leaves them unchanged.
- R9: If command bit 8 was clear, done leaves `host_irq` at 0.
- R10: Accepting a command clears the error bit and the result code. Status bits 11:8 show the subcommand of the last accepted command.
- R11: A done pulse while idle changes nothing. Bus writes to the read buffer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, registered |
| host_irq | output | 1 | Completion interrupt, level |
| ctl_start | output | 1 | One-cycle transaction start to the controller |
| ctl_code | output | 8 | Command code |
| ctl_sub | output | 4 | Subcommand |
| ctl_size | output | 8 | Payload size in bytes |
| ctl_src_ptr | output | 32 | Source pointer snapshot |
| ctl_dst_ptr | output | 32 | Destination pointer snapshot |
| ctl_payload | output | 128 | Masked payload, byte k at bits 8k+7:8k |
| ctl_done | input | 1 | Completion pulse from the controller |
| ctl_err_code | input | 8 | Result code with the completion |
| ctl_resp | input | 128 | Response words, word i at bits 32i+31:32i |

## Verification
Every result of this block is due one edge after its cause. Busy, `ctl_start` and its fields follow the edge that takes the command write. Busy clearing, the interrupt and the read buffer follow the edge that takes done. Read data follows the edge that takes the read strobe. The bench drives each stimulus at the falling edge and samples 1 ns after the next rising edge, so each check lands in the cycle the result is due. To show that the start pulse lasts exactly one cycle, the bench samples it again one edge later.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int unsigned MBX_AW = 8;

  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_SRC  = 8'h08;
  localparam logic [7:0] OFS_DST  = 8'h0C;
  localparam logic [7:0] OFS_WBUF = 8'h80;
  localparam logic [7:0] OFS_RBUF = 8'h90;

  typedef struct packed {
    logic [7:0] rsvd_hi;
    logic [7:0] size;
    logic [3:0] sub;
    logic [2:0] rsvd_lo;
    logic       irq_req;
    logic [7:0] code;
  } mbx_cmd_t;

  function automatic logic [31:0] mbx_pack_status(input logic busy, input logic [7:0] code,
                                                  input logic irqf, input logic [3:0] cid,
                                                  input logic ovr);
    logic [31:0] w;
    w        = '0;
    w[0]     = busy;
    w[1]     = |code;
    w[2]     = irqf;
    w[11:8]  = cid;
    w[23:16] = code;
    w[24]    = ovr;
    return w;
  endfunction

  function automatic logic mbx_in_window(input logic [7:0] a, input logic [7:0] base,
                                         input int unsigned words);
    return (int'(a) >= int'(base)) && (int'(a) < int'(base) + 4 * int'(words)) &&
           (a[1:0] == 2'b00);
  endfunction

  function automatic int unsigned mbx_word_idx(input logic [7:0] a, input logic [7:0] base);
    return (int'(a) - int'(base)) >> 2;
  endfunction

endpackage

// File: rtl/mbx_wbuf.sv
module mbx_wbuf #(
  parameter int unsigned BUF_WORDS = 4,
  localparam int unsigned BUF_W = BUF_WORDS * 32,
  localparam int unsigned IDX_W = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_word,
  input  logic [7:0]       mask_size,
  output logic [BUF_W-1:0] payload_o
);

  logic [31:0] words [BUF_WORDS];

  for (genvar w = 0; w < BUF_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  words[w] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(w)))     words[w] <= wr_data;
    end
    for (genvar b = 0; b < 4; b++) begin : g_byte
      assign payload_o[w*32 + b*8 +: 8] =
        (8'(w*4 + b) < mask_size) ? words[w][b*8 +: 8] : 8'h00;
    end
  end

  assign rd_word = words[rd_idx];

endmodule

// File: rtl/mbx_rbuf.sv
module mbx_rbuf #(
  parameter int unsigned BUF_WORDS = 4,
  localparam int unsigned BUF_W = BUF_WORDS * 32,
  localparam int unsigned IDX_W = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BUF_W-1:0] resp,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_word
);

  logic [31:0] words [BUF_WORDS];

  for (genvar w = 0; w < BUF_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    words[w] <= '0;
      else if (load) words[w] <= resp[w*32 +: 32];
    end
  end

  assign rd_word = words[rd_idx];

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic        stat_wr,
  input  logic [31:0] wdata,
  input  logic        done,
  input  logic [7:0]  done_code,
  output logic        accept,
  output logic        finish,
  output logic        start,
  output logic        irq,
  output mbx_cmd_t    cmd_q,
  output logic [31:0] status_word
);

  logic       busy;
  logic       ie_q;
  logic       irqf;
  logic       ovr;
  logic [7:0] code_q;
  logic       reject;
  logic       irq_clear;
  mbx_cmd_t   cmd_in;

  assign cmd_in    = mbx_cmd_t'(wdata);
  assign accept    = cmd_wr && !busy;
  assign reject    = cmd_wr && busy;
  assign finish    = done && busy;
  assign irq_clear = stat_wr && wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      start  <= 1'b0;
      ie_q   <= 1'b0;
      irqf   <= 1'b0;
      ovr    <= 1'b0;
      code_q <= '0;
      cmd_q  <= '0;
    end else begin
      start <= accept;
      if (accept) begin
        busy   <= 1'b1;
        cmd_q  <= cmd_in;
        ie_q   <= cmd_in.irq_req;
        code_q <= '0;
      end
      if (reject) ovr <= 1'b1;
      if (irq_clear) irqf <= 1'b0;
      if (finish) begin
        busy   <= 1'b0;
        code_q <= done_code;
        if (ie_q) irqf <= 1'b1;
      end
    end
  end

  assign irq         = irqf;
  assign status_word = mbx_pack_status(busy, code_q, irqf, cmd_q.sub, ovr);

  AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> busy);                                                     // R3
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);                                                   // R3
  AST_REJECT_KEEPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> ($stable(cmd_q) && ovr && !start));                       // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr);                                                        // R5
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy);                                                   // R6
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clear) |=> irq);                                        // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(finish));                                       // R9

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned BUF_WORDS = 4,
  localparam int unsigned BUF_W = BUF_WORDS * 32,
  localparam int unsigned IDX_W = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             host_irq,
  output logic             ctl_start,
  output logic [7:0]       ctl_code,
  output logic [3:0]       ctl_sub,
  output logic [7:0]       ctl_size,
  output logic [31:0]      ctl_src_ptr,
  output logic [31:0]      ctl_dst_ptr,
  output logic [BUF_W-1:0] ctl_payload,
  input  logic             ctl_done,
  input  logic [7:0]       ctl_err_code,
  input  logic [BUF_W-1:0] ctl_resp
);

  logic             hit_cmd, hit_stat, hit_src, hit_dst, hit_wbuf, hit_rbuf;
  logic [IDX_W-1:0] wbuf_idx, rbuf_idx;
  logic [31:0]      wbuf_word, rbuf_word, status_word;
  logic [31:0]      src_q, dst_q;
  logic [BUF_W-1:0] payload_masked;
  logic             accept, finish;
  mbx_cmd_t         cmd_q, cmd_in;

  assign cmd_in   = mbx_cmd_t'(bus_wdata);
  assign hit_cmd  = (bus_addr == OFS_CMD);
  assign hit_stat = (bus_addr == OFS_STAT);
  assign hit_src  = (bus_addr == OFS_SRC);
  assign hit_dst  = (bus_addr == OFS_DST);
  assign hit_wbuf = mbx_in_window(bus_addr, OFS_WBUF, BUF_WORDS);
  assign hit_rbuf = mbx_in_window(bus_addr, OFS_RBUF, BUF_WORDS);
  assign wbuf_idx = IDX_W'(mbx_word_idx(bus_addr, OFS_WBUF));
  assign rbuf_idx = IDX_W'(mbx_word_idx(bus_addr, OFS_RBUF));

  mbx_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (bus_wr && hit_cmd),
    .stat_wr    (bus_wr && hit_stat),
    .wdata      (bus_wdata),
    .done       (ctl_done),
    .done_code  (ctl_err_code),
    .accept     (accept),
    .finish     (finish),
    .start      (ctl_start),
    .irq        (host_irq),
    .cmd_q      (cmd_q),
    .status_word(status_word)
  );

  mbx_wbuf #(.BUF_WORDS(BUF_WORDS)) u_wbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr && hit_wbuf),
    .wr_idx   (wbuf_idx),
    .wr_data  (bus_wdata),
    .rd_idx   (wbuf_idx),
    .rd_word  (wbuf_word),
    .mask_size(cmd_in.size),
    .payload_o(payload_masked)
  );

  mbx_rbuf #(.BUF_WORDS(BUF_WORDS)) u_rbuf (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (finish),
    .resp   (ctl_resp),
    .rd_idx (rbuf_idx),
    .rd_word(rbuf_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (bus_wr) begin
      if (hit_src) src_q <= bus_wdata;
      if (hit_dst) dst_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_src_ptr <= '0;
      ctl_dst_ptr <= '0;
      ctl_payload <= '0;
    end else if (accept) begin
      ctl_src_ptr <= src_q;
      ctl_dst_ptr <= dst_q;
      ctl_payload <= payload_masked;
    end
  end

  assign ctl_code = cmd_q.code;
  assign ctl_sub  = cmd_q.sub;
  assign ctl_size = cmd_q.size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) begin
      if (hit_cmd)       bus_rdata <= 32'(cmd_q);
      else if (hit_stat) bus_rdata <= status_word;
      else if (hit_src)  bus_rdata <= src_q;
      else if (hit_dst)  bus_rdata <= dst_q;
      else if (hit_wbuf) bus_rdata <= wbuf_word;
      else if (hit_rbuf) bus_rdata <= rbuf_word;
      else               bus_rdata <= '0;
    end
  end

  AST_PTR_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ctl_src_ptr == $past(src_q) && ctl_dst_ptr == $past(dst_q))); // R3
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(ctl_payload) && $stable(ctl_code)));                 // R5

endmodule

// File: tb/test_cmd_mailbox.sv
`timescale 1ns/1ps
module test_cmd_mailbox;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         host_irq, ctl_start;
  logic [7:0]   ctl_code, ctl_size;
  logic [3:0]   ctl_sub;
  logic [31:0]  ctl_src_ptr, ctl_dst_ptr;
  logic [127:0] ctl_payload;
  logic         ctl_done = 1'b0;
  logic [7:0]   ctl_err_code = '0;
  logic [127:0] ctl_resp = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cmd_mailbox i_cmd_mailbox (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_irq(host_irq),
    .ctl_start(ctl_start), .ctl_code(ctl_code), .ctl_sub(ctl_sub), .ctl_size(ctl_size),
    .ctl_src_ptr(ctl_src_ptr), .ctl_dst_ptr(ctl_dst_ptr), .ctl_payload(ctl_payload),
    .ctl_done(ctl_done), .ctl_err_code(ctl_err_code), .ctl_resp(ctl_resp)
  );

  // {command word, result code}
  localparam logic [39:0] VEC [6] = '{
    {32'h0004_11EE, 8'h00},
    {32'h0010_F0F0, 8'h05},
    {32'h0000_31ED, 8'h07},
    {32'h0007_A1EC, 8'h00},
    {32'h0014_20EB, 8'h06},
    {32'h000D_51FF, 8'h01}
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1; d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic cdone(input logic [7:0] code, input logic [127:0] resp);
    @(negedge clk); ctl_done = 1'b1; ctl_err_code = code; ctl_resp = resp;
    @(posedge clk); #1; ctl_done = 1'b0;
  endtask

  function automatic logic [31:0] wword(input int v, input int k);
    return 32'hA000_0000 | 32'(v << 16) | 32'(k << 8) | 32'((k * 17 + v) & 8'hFF);
  endfunction

  function automatic logic [31:0] rword(input int v, input int k);
    return 32'hC000_0000 + 32'(v * 16 + k);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd, cw, st, exp_st;
    logic [127:0] resp, exp_pl;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    brd(OFS(8'h04), rd); check("R1 status", 128'(rd), 128'(0));
    brd(8'h00, rd);      check("R1 command", 128'(rd), 128'(0));
    brd(8'h94, rd);      check("R1 read buffer", 128'(rd), 128'(0));
    check("R1 irq", 128'(host_irq), 128'(0));
    check("R1 start", 128'(ctl_start), 128'(0));

    // R2 pointer and buffer readback, unmapped read
    bwr(8'h08, 32'h1111_2222); bwr(8'h0C, 32'h3333_4444); bwr(8'h88, 32'h5555_6666);
    brd(8'h08, rd); check("R2 src ptr", 128'(rd), 128'(32'h1111_2222));
    brd(8'h0C, rd); check("R2 dst ptr", 128'(rd), 128'(32'h3333_4444));
    brd(8'h88, rd); check("R2 wbuf word", 128'(rd), 128'(32'h5555_6666));
    brd(8'h40, rd); check("R2 unmapped", 128'(rd), 128'(0));

    // vector loop: R3 R4 R6 R7 R8 R9 R10
    for (int v = 0; v < 6; v++) begin
      cw = VEC[v][39:8];
      for (int k = 0; k < 4; k++) bwr(8'h80 + 8'(4 * k), wword(v, k));
      bwr(8'h08, 32'h0000_1000 + 32'(v)); bwr(8'h0C, 32'h0000_2000 + 32'(v));
      bwr(8'h00, cw);
      check("R3 start pulse", 128'(ctl_start), 128'(1));
      check("R3 code", 128'(ctl_code), 128'(cw[7:0]));
      check("R3 sub", 128'(ctl_sub), 128'(cw[15:12]));
      check("R3 size", 128'(ctl_size), 128'(cw[23:16]));
      check("R3 src", 128'(ctl_src_ptr), 128'(32'h0000_1000 + 32'(v)));
      check("R3 dst", 128'(ctl_dst_ptr), 128'(32'h0000_2000 + 32'(v)));
      exp_pl = '0;
      for (int b = 0; b < 16; b++)
        if (b < int'(cw[23:16])) exp_pl[b*8 +: 8] = wword(v, b / 4) >> (8 * (b % 4));
      check("R4 payload mask", ctl_payload, exp_pl);
      @(posedge clk); #1;
      check("R3 start one cycle", 128'(ctl_start), 128'(0));
      brd(8'h04, st);
      check("R10 busy status cleared err", 128'(st), 128'(32'h1 | (32'(cw[15:12]) << 8)));
      resp = '0;
      for (int k = 0; k < 4; k++) resp[k*32 +: 32] = rword(v, k);
      cdone(VEC[v][7:0], resp);
      check(cw[8] ? "R8 irq raised" : "R9 irq stays low", 128'(host_irq), 128'(cw[8]));
      exp_st = (32'(VEC[v][7:0] != 0) << 1) | (32'(cw[8]) << 2) |
               (32'(cw[15:12]) << 8) | (32'(VEC[v][7:0]) << 16);
      brd(8'h04, st); check("R7 status after done", 128'(st), 128'(exp_st));
      for (int k = 0; k < 4; k++) begin
        brd(8'h90 + 8'(4 * k), rd); check("R6 read buffer", 128'(rd), 128'(rword(v, k)));
      end
      if (cw[8]) begin
        bwr(8'h04, 32'hFFFF_FFFB);
        check("R8 write-0 keeps irq", 128'(host_irq), 128'(1));
        bwr(8'h04, 32'h0000_0004);
        check("R8 write-1 clears irq", 128'(host_irq), 128'(0));
      end
    end

    // R11 done while idle, write to read buffer
    brd(8'h04, exp_st);
    cdone(8'h03, {4{32'hDEAD_BEEF}});
    brd(8'h04, st); check("R11 idle done status", 128'(st), 128'(exp_st));
    bwr(8'h98, 32'h1234_5678);
    brd(8'h98, rd); check("R11 rbuf write ignored", 128'(rd), 128'(rword(5, 2)));
    check("R11 idle done no irq", 128'(host_irq), 128'(0));

    // R5 command while busy
    bwr(8'h00, 32'h0004_2011);
    bwr(8'h00, 32'h0008_3022);
    check("R5 no second start", 128'(ctl_start), 128'(0));
    brd(8'h00, rd); check("R5 command kept", 128'(rd), 128'(32'h0004_2011));
    brd(8'h04, st); check("R5 overrun set", 128'(st[24]), 128'(1));
    cdone(8'h00, '0);
    brd(8'h04, st); check("R5 overrun sticky", 128'(st), 128'(32'h0100_0200));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [7:0] OFS(input logic [7:0] a);
    return a;
  endfunction

endmodule